// File: doc/BRIEF.md
# Paired-Word Half-Rate Sample Delay

This block delays a stream of pixel samples by a number of samples chosen at run time. It is meant for the row-to-row link of a systolic correlation or filter array. There, each row's partial result must wait one image row minus one template row before it joins the next row of multipliers.

The block never stores one sample at a time. Two consecutive accepted samples are joined into one double-width word. That word is written into a small memory on the cycle that completes the pair. One word is also read back on that same cycle. The memory is therefore touched at most once every two clock cycles, but the stream still moves one sample per clock. On the far side, a word register hands out its two halves in order. A one-sample skew register covers odd delay settings, so the delay is exact for every legal length.

The delay is counted in accepted samples. Cycles with the input valid low leave the line frozen.

Top module: `pair_delay_line`

## Requirements
- R1: While reset is high and in the cycle after reset is released, `out_valid` is low and `out_sample` is zero.
- R2: For an even length L, the sample accepted as number n (counting from 0 after reset) is presented on `out_sample` with `out_valid` high in the cycle that follows acceptance of sample number n+L.
- R3: For an odd length L, the same timing as R2 holds exactly. There is no rounding of the delay to an even count.
- R4: `out_valid` never goes high for an accepted sample whose index is below L. No sample comes out before L samples have entered since reset.
- R5: A cycle with `in_valid` low neither advances the line nor counts toward the delay. In the following cycle `out_valid` is low and `out_sample` keeps its previous value.
- R6: The storage memory is written only on an accepted sample that completes a pair (the second, fourth, ... sample after reset). It is never accessed on two consecutive cycles. The earlier sample of a pair occupies the low half of the word and is emitted first.
- R7: Both ends of the legal range work: L equal to 4 and L equal to MAX_LEN (64 by default), in both parities near the top (MAX_LEN and MAX_LEN-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock; one sample per cycle at most |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a cycle that carries an input sample |
| in_sample | input | DATA_W | Input sample |
| dly_len | input | LEN_W | Delay in samples, 4 to MAX_LEN, held stable between resets |
| out_valid | output | 1 | Marks a cycle that carries a delayed sample |
| out_sample | output | DATA_W | Delayed sample |

## Verification
The bench targets odd lengths. A design that dropped the skew register would emit every sample one position early or late, and it would swap the halves of each pair. The bench also sweeps both ends of the length range. An off-by-one in the read offset shows up at length 4 as a read of a word that is still being written. At length 64 it shows up as a read of a word that has already been overwritten. Gapped input is used to catch a line that advances on idle cycles, which would shorten the delay. It also catches an output that changes while invalid. The fill phase after each reset is watched for any early `out_valid`.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

    // Position of the next accepted sample inside its pair.
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } pair_phase_e;

    // Shortest delay the paired read timing supports.
    localparam int unsigned MIN_LEN = 4;

    // Number of words between the word being written and the word to read.
    // An odd length reuses the even stream one below it and then adds the skew.
    function automatic int unsigned word_lag(int unsigned len);
        return (len / 2) - 1;
    endfunction

endpackage

// File: rtl/pdl_packer.sv
module pdl_packer
    import pdl_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [DATA_W-1:0]          in_sample,
    output pair_phase_e                phase,
    output logic                       wr_en,
    output logic [1:0][DATA_W-1:0]     wr_word
);

    logic [DATA_W-1:0] first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_FIRST;
            first_q <= '0;
        end else if (in_valid) begin
            if (phase == PH_FIRST) begin
                first_q <= in_sample;
                phase   <= PH_SECOND;
            end else begin
                phase   <= PH_FIRST;
            end
        end
    end

    // A word is complete only when the second sample of a pair arrives.
    assign wr_en      = in_valid && (phase == PH_SECOND);
    assign wr_word[0] = first_q;
    assign wr_word[1] = in_sample;

endmodule

// File: rtl/pdl_store.sv
module pdl_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [1:0][DATA_W-1:0]     wr_word,
    input  logic [ADDR_W-1:0]          rd_lag,
    output logic [1:0][DATA_W-1:0]     rd_word
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [1:0][DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0]      wptr_q;
    logic [ADDR_W-1:0]      raddr;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wptr_q] <= wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
        end else if (wr_en) begin
            wptr_q <= wptr_q + 1'b1;
        end
    end

    // The read shares the write cycle; the word read was written earlier.
    assign raddr   = wptr_q - rd_lag;
    assign rd_word = mem[raddr];

endmodule

// File: rtl/pdl_unpacker.sv
module pdl_unpacker
    import pdl_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  pair_phase_e                phase,
    input  logic                       load,
    input  logic [1:0][DATA_W-1:0]     rd_word,
    input  logic                       odd_len,
    input  logic                       emit,
    output logic                       out_valid,
    output logic [DATA_W-1:0]          out_sample
);

    logic [1:0][DATA_W-1:0] cur_q;
    logic [DATA_W-1:0]      skew_q;
    logic [DATA_W-1:0]      even_tap;

    // Low half on the first sample of a pair, high half on the second.
    assign even_tap = (phase == PH_FIRST) ? cur_q[0] : cur_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q      <= '0;
            skew_q     <= '0;
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= emit;
            if (in_valid) begin
                skew_q <= even_tap;
                if (load) begin
                    cur_q <= rd_word;
                end
                if (emit) begin
                    out_sample <= odd_len ? skew_q : even_tap;
                end
            end
        end
    end

endmodule

// File: rtl/pair_delay_line.sv
module pair_delay_line
    import pdl_pkg::*;
#(
    parameter  int unsigned DATA_W  = 8,
    parameter  int unsigned MAX_LEN = 64,
    localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1),
    localparam int unsigned ADDR_W  = $clog2(MAX_LEN / 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_sample,
    input  logic [LEN_W-1:0]   dly_len,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_sample
);

    pair_phase_e            phase;
    logic                   wr_en;
    logic [1:0][DATA_W-1:0] wr_word;
    logic [1:0][DATA_W-1:0] rd_word;
    logic [ADDR_W-1:0]      rd_lag;
    logic [LEN_W-1:0]       fill_q;
    logic                   emit;

    // Accepted-sample counter, saturating once any legal length is covered.
    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
        end else if (in_valid && (fill_q < LEN_W'(MAX_LEN))) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    assign emit   = in_valid && (fill_q >= dly_len);
    assign rd_lag = ADDR_W'(word_lag(32'(dly_len)));

    pdl_packer #(.DATA_W(DATA_W)) packer_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .phase     (phase),
        .wr_en     (wr_en),
        .wr_word   (wr_word)
    );

    pdl_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) store_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .rd_lag  (rd_lag),
        .rd_word (rd_word)
    );

    pdl_unpacker #(.DATA_W(DATA_W)) unpacker_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .phase      (phase),
        .load       (wr_en),
        .rd_word    (rd_word),
        .odd_len    (dly_len[0]),
        .emit       (emit),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

endmodule

// File: rtl/pdl_checker.sv
module pdl_checker #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned LEN_W  = 7
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [LEN_W-1:0]   dly_len,
    input logic               out_valid,
    input logic [DATA_W-1:0]  out_sample,
    input logic               wr_en
);

    logic [31:0] seen_q;
    logic        odd_q;
    logic        rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            seen_q <= '0;
            odd_q  <= 1'b0;
        end else if (in_valid) begin
            if (seen_q != 32'hFFFF_FFFF) seen_q <= seen_q + 1;
            odd_q <= ~odd_q;
        end
    end

    // R1: outputs cleared by reset
    always_ff @(posedge clk) begin
        if (rst_d === 1'b1) begin
            a_reset_clear_r1: assert (!out_valid && out_sample == '0)
                else $error("reset state wrong");
        end
    end

    p_write_on_pair_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (in_valid && odd_q));

    p_half_rate_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    p_no_early_output_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(seen_q) >= 32'($past(dly_len))));

    p_valid_needs_accept_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    p_hold_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_sample));

endmodule

bind pair_delay_line pdl_checker #(.DATA_W(DATA_W), .LEN_W(LEN_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .dly_len    (dly_len),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .wr_en      (wr_en)
);

// File: tb/pair_delay_line_tb_top.sv
module pair_delay_line_tb_top;

    localparam int unsigned DATA_W  = 8;
    localparam int unsigned MAX_LEN = 64;
    localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_sample = '0;
    logic [LEN_W-1:0]  dly_len = LEN_W'(4);
    logic              out_valid;
    logic [DATA_W-1:0] out_sample;

    int                checks = 0;
    int                errors = 0;
    logic [DATA_W-1:0] exp_q[$];
    logic [DATA_W-1:0] want;
    logic [DATA_W-1:0] last_out = '0;
    logic [15:0]       lfsr = 16'hACE1;
    string             tag = "R1";

    always #4 clk = ~clk;   // 125 MHz

    pair_delay_line #(.DATA_W(DATA_W), .MAX_LEN(MAX_LEN)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .dly_len    (dly_len),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    // Monitor: compares each delayed sample with the scoreboard head.
    always @(negedge clk) begin
        if (rst) begin
            last_out = '0;
        end else if (out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4 (%s): output %0h valid before fill, expected no output", tag, out_sample);
            end else begin
                want = exp_q.pop_front();
                if (out_sample !== want) begin
                    errors++;
                    $display("FAIL %s: got %0h expected %0h", tag, out_sample, want);
                end
            end
            last_out = out_sample;
        end else begin
            checks++;
            if (out_sample !== last_out) begin
                errors++;
                $display("FAIL R5: idle output moved to %0h expected %0h", out_sample, last_out);
            end
        end
    end

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // Driver: feeds samples and pushes the expected delayed ones.
    task automatic run_case(input int len, input int count, input bit gaps, input string t);
        logic [DATA_W-1:0] hist[$];
        int acc = 0;
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b0;
        dly_len  = LEN_W'(len);
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_sample !== '0) begin
            errors++;
            $display("FAIL R1: reset outputs %0b/%0h expected 0/0", out_valid, out_sample);
        end
        exp_q.delete();
        tag = t;
        rst = 1'b0;
        while (acc < count) begin
            @(negedge clk);
            step_lfsr();
            if (gaps && lfsr[0] && lfsr[3]) begin
                in_valid = 1'b0;
            end else begin
                in_valid  = 1'b1;
                in_sample = lfsr[15:8];
                hist.push_back(in_sample);
                if (acc >= len) exp_q.push_back(hist[acc - len]);
                acc++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d samples never emitted, expected 0", t, exp_q.size());
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_sample !== '0) begin
            errors++;
            $display("FAIL R1: initial reset outputs %0b/%0h expected 0/0", out_valid, out_sample);
        end
        // R6: a gap-free stream at one sample per cycle is carried through the
        // half-rate paired storage; any packing or half-order fault breaks R2/R3 data.
        run_case(6,  300, 1'b0, "R2 R6");
        run_case(4,  200, 1'b0, "R2 R7");
        run_case(5,  300, 1'b0, "R3 R6");
        run_case(17, 300, 1'b1, "R3 R5");
        run_case(64, 400, 1'b0, "R2 R7");
        run_case(63, 400, 1'b0, "R3 R7");
        run_case(4,  300, 1'b1, "R5 R7");
        run_case(30, 300, 1'b1, "R2 R5");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule